// File: doc/BRIEF.md
# External SRAM Bus Sizing Controller

This controller sits between an internal 32-bit request bus and an external asynchronous SRAM. The internal side sends byte, halfword or word reads and writes through a valid/ready handshake. The controller turns each one into one or more external access beats on an 8-bit or 16-bit device. Each beat drives address and data, an active-low chip select, an output enable and write strobes. Multi-byte data always maps little endian: the least significant byte goes to the lowest byte address.

Three things are set per request and latched when it is accepted: the port width, the 16-bit strobe style and a wait-state count. The 16-bit strobe style is either two per-lane write enables, or one shared write enable together with two lane-select outputs.

Each beat holds chip select and its strobes low for 1 + wait clocks. Every strobe then returns high for one clock before the next beat begins. A request whose address does not suit its size never reaches the pins. It is answered at once with an error flag.

Top module: `sbc_ctrl`

## Requirements
- R1: Size codes are 00 byte, 01 halfword, 10 word. A halfword with address bit 0 set, a word with address bits [1:0] not 00, or size code 11 starts no external beat. Chip select stays high, and `req_ready` pulses with `rsp_err`=1 on the clock after acceptance.
- R2: Beats per request: on an 8-bit port, 1, 2 or 4 for byte, halfword or word, at byte addresses A, A+1, … in ascending order. On a 16-bit port, 1, 1 or 2, at halfword addresses A>>1, (A>>1)+1.
- R3: A write stores byte k of `req_wdata` at byte address A+k, leaving all other bytes unchanged. On a 16-bit port, a byte write stores only the lane chosen by A[0] (0 = low lane).
- R4: Read data returns little endian and zero-extended in `rsp_rdata`. On a 16-bit port, a byte read takes `ext_din[7:0]` when A[0]=0 and `ext_din[15:8]` when A[0]=1, and places it in bits [7:0].
- R5: 8-bit port: `ext_addr` is the byte address, data uses `ext_dout[7:0]`/`ext_din[7:0]`, and writes pulse `ext_we_lo_n` only. `ext_we_hi_n`, `ext_bs_lo_n` and `ext_bs_hi_n` stay high.
- R6: 16-bit port, per-lane write mode (`cfg_bsel`=0): `ext_addr` is the byte address shifted right by one. `ext_we_lo_n`/`ext_we_hi_n` go low only for the lanes being written, reads use `ext_oe_n`, and both lane selects stay high.
- R7: 16-bit port, lane-select mode (`cfg_bsel`=1): writes use `ext_we_lo_n` as the single write strobe and `ext_we_hi_n` stays high. `ext_bs_lo_n`/`ext_bs_hi_n` go low for the active lanes on reads and writes.
- R8: Every beat holds `ext_ce_n` low for exactly `cfg_wait`+1 clocks with a stable address, and one all-high clock separates beats. All strobes are active low and only active while chip select is low. `ext_oe_n` is low only on reads, and a write strobe is low only on writes.
- R9: `req_ready` is high for exactly one clock per request, on the clock after the last beat, with `rsp_err`=0 for an aligned request. For N beats the pulse comes N·(wait+1)+N clocks after acceptance.
- R10: While reset is held, and after it, chip select, output enable, write strobes and lane selects are high, `ext_doe` is low and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1 = 16-bit device, 0 = 8-bit device |
| cfg_bsel | input | 1 | 16-bit strobe style: 1 = shared write enable plus lane selects |
| cfg_wait | input | WAIT_W | Extra clocks per beat |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data, little endian |
| req_ready | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Misalignment error, valid with `req_ready` |
| rsp_rdata | output | 32 | Read data, valid with `req_ready` |
| ext_addr | output | ADDR_W | External address |
| ext_dout | output | 16 | External write data |
| ext_doe | output | 1 | Drive enable for external data lines |
| ext_din | input | 16 | External read data |
| ext_ce_n | output | 1 | Chip select, active low |
| ext_oe_n | output | 1 | Output enable / read strobe, active low |
| ext_we_lo_n | output | 1 | Low-lane or shared write strobe, active low |
| ext_we_hi_n | output | 1 | High-lane write strobe, active low |
| ext_bs_lo_n | output | 1 | Low-lane select, active low |
| ext_bs_hi_n | output | 1 | High-lane select, active low |

## Verification
The bench attaches a byte-array SRAM model that reacts to the strobes as a real device would. It goes after misaligned halfwords and words and the reserved size code. A design that let those through would move chip select or corrupt memory instead of flagging an error. Byte accesses at odd addresses on the 16-bit port expose a swapped lane select or a misplaced read byte. Word accesses in each width show up beat-order or endianness mistakes as wrong bytes at wrong addresses. All eight wait settings check the beat length and the gap clock, and a wrong count there shows up as a wrong latency or chip-select-low count.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    localparam int unsigned INT_W = 32;
    localparam int unsigned EXT_W = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BEAT,
        ST_GAP,
        ST_RESP
    } state_e;

    typedef struct packed {
        logic  write;
        size_e size;
        logic  wide;
        logic  bsel;
    } ctl_t;

    typedef struct packed {
        logic lo;
        logic hi;
    } lanes_t;

    function automatic logic bad_align(input size_e sz, input logic [1:0] a);
        case (sz)
            SZ_BYTE: return 1'b0;
            SZ_HALF: return a[0];
            SZ_WORD: return |a;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [2:0] beat_total(input size_e sz, input logic wide);
        if (wide)
            return (sz == SZ_WORD) ? 3'd2 : 3'd1;
        case (sz)
            SZ_HALF: return 3'd2;
            SZ_WORD: return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/sbc_align.sv
module sbc_align
    import sbc_pkg::*;
(
    input  size_e      size,
    input  logic [1:0] addr_lsb,
    output logic       bad
);
    always_comb bad = bad_align(size, addr_lsb);
endmodule

// File: rtl/sbc_wait_timer.sv
module sbc_wait_timer #(
    parameter int unsigned WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [WAIT_W-1:0] limit,
    output logic              done
);
    logic [WAIT_W-1:0] cnt;

    always_comb done = run && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run || done)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= limit)); // R8
endmodule

// File: rtl/sbc_beat_map.sv
module sbc_beat_map
    import sbc_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  ctl_t              ctl,
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        beat,
    input  logic [INT_W-1:0]  wdata,
    input  logic [EXT_W-1:0]  din,
    input  logic [INT_W-1:0]  acc_in,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [EXT_W-1:0]  dout,
    output lanes_t            lanes,
    output logic              last,
    output logic [INT_W-1:0]  acc_next
);
    logic [2:0]       nb;
    logic [INT_W-1:0] sh_b;
    logic [INT_W-1:0] sh_h;

    always_comb begin
        nb   = beat_total(ctl.size, ctl.wide);
        last = ({1'b0, beat} == (nb - 3'd1));
        sh_b = wdata >> {beat, 3'b000};
        sh_h = wdata >> {beat[0], 4'b0000};
    end

    // address, lanes and write data of the current beat
    always_comb begin
        if (!ctl.wide) begin
            ext_addr = base + ADDR_W'(beat);
            dout     = {8'h00, sh_b[7:0]};
            lanes    = '{lo: 1'b1, hi: 1'b0};
        end else if (ctl.size == SZ_BYTE) begin
            ext_addr = {1'b0, base[ADDR_W-1:1]};
            dout     = {wdata[7:0], wdata[7:0]};
            lanes    = '{lo: !base[0], hi: base[0]};
        end else begin
            ext_addr = {1'b0, base[ADDR_W-1:1]} + ADDR_W'(beat);
            dout     = sh_h[15:0];
            lanes    = '{lo: 1'b1, hi: 1'b1};
        end
    end

    // merge of the sampled read data into the response word
    always_comb begin
        acc_next = acc_in;
        if (!ctl.wide)
            acc_next[{beat, 3'b000} +: 8] = din[7:0];
        else if (ctl.size == SZ_BYTE)
            acc_next[7:0] = base[0] ? din[15:8] : din[7:0];
        else
            acc_next[{beat[0], 4'b0000} +: 16] = din;
    end
endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
    import sbc_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wide,
    input  logic              cfg_bsel,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              req_ready,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [15:0]       ext_dout,
    output logic              ext_doe,
    input  logic [15:0]       ext_din,
    output logic              ext_ce_n,
    output logic              ext_oe_n,
    output logic              ext_we_lo_n,
    output logic              ext_we_hi_n,
    output logic              ext_bs_lo_n,
    output logic              ext_bs_hi_n
);
    state_e            state;
    ctl_t              ctl;
    logic [ADDR_W-1:0] addr_q;
    logic [INT_W-1:0]  wdata_q;
    logic [WAIT_W-1:0] wait_q;
    logic [1:0]        beat_q;
    logic [INT_W-1:0]  acc_q;
    logic              err_q;

    logic              bad;
    logic              beat_done;
    logic              last;
    lanes_t            lanes;
    logic [INT_W-1:0]  acc_next;
    logic              in_beat;
    logic              wr_act;

    sbc_align u_align (
        .size     (size_e'(req_size)),
        .addr_lsb (req_addr[1:0]),
        .bad      (bad)
    );

    sbc_beat_map #(.ADDR_W(ADDR_W)) u_map (
        .ctl      (ctl),
        .base     (addr_q),
        .beat     (beat_q),
        .wdata    (wdata_q),
        .din      (ext_din),
        .acc_in   (acc_q),
        .ext_addr (ext_addr),
        .dout     (ext_dout),
        .lanes    (lanes),
        .last     (last),
        .acc_next (acc_next)
    );

    sbc_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (in_beat),
        .limit (wait_q),
        .done  (beat_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ctl     <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            wait_q  <= '0;
            beat_q  <= '0;
            acc_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        ctl     <= '{write: req_write, size: size_e'(req_size),
                                     wide: cfg_wide, bsel: cfg_bsel};
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        wait_q  <= cfg_wait;
                        beat_q  <= '0;
                        acc_q   <= '0;
                        err_q   <= bad;
                        state   <= bad ? ST_RESP : ST_BEAT;
                    end
                end
                ST_BEAT: begin
                    if (beat_done) begin
                        if (!ctl.write)
                            acc_q <= acc_next;
                        if (last) begin
                            state <= ST_RESP;
                        end else begin
                            beat_q <= beat_q + 2'd1;
                            state  <= ST_GAP;
                        end
                    end
                end
                ST_GAP:  state <= ST_BEAT;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // strobe generation per port style
    always_comb begin
        in_beat     = (state == ST_BEAT);
        wr_act      = in_beat && ctl.write;
        ext_ce_n    = !in_beat;
        ext_oe_n    = !(in_beat && !ctl.write);
        ext_doe     = wr_act;
        ext_we_lo_n = 1'b1;
        ext_we_hi_n = 1'b1;
        ext_bs_lo_n = 1'b1;
        ext_bs_hi_n = 1'b1;
        if (!ctl.wide) begin
            ext_we_lo_n = !wr_act;
        end else if (!ctl.bsel) begin
            ext_we_lo_n = !(wr_act && lanes.lo);
            ext_we_hi_n = !(wr_act && lanes.hi);
        end else begin
            ext_we_lo_n = !wr_act;
            ext_bs_lo_n = !(in_beat && lanes.lo);
            ext_bs_hi_n = !(in_beat && lanes.hi);
        end
    end

    always_comb begin
        req_ready = (state == ST_RESP);
        rsp_err   = err_q;
        rsp_rdata = acc_q;
    end

    AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        (req_ready && rsp_err) |-> $past(ext_ce_n)); // R1
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready); // R9
    AST_STROBE_IN_CE: assert property (@(posedge clk) disable iff (rst)
        (!ext_oe_n || !ext_we_lo_n || !ext_we_hi_n || !ext_bs_lo_n || !ext_bs_hi_n)
        |-> !ext_ce_n); // R8
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!ext_oe_n && (!ext_we_lo_n || !ext_we_hi_n))); // R8
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!ext_ce_n && $past(!ext_ce_n)) |-> $stable(ext_addr)); // R8
    AST_NARROW_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ctl.wide |-> (ext_we_hi_n && ext_bs_lo_n && ext_bs_hi_n)); // R5
    AST_WIDE_BYTE_LANE: assert property (@(posedge clk) disable iff (rst)
        (!ext_ce_n && ctl.wide && ctl.size == SZ_BYTE) |-> $onehot({lanes.lo, lanes.hi})); // R6
    AST_BSEL_ONE_WE: assert property (@(posedge clk) disable iff (rst)
        (ctl.wide && ctl.bsel) |-> ext_we_hi_n); // R7
endmodule

// File: tb/sbc_ctrl_bench.sv
module sbc_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_N = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wide = 1'b0, cfg_bsel = 1'b0;
    logic [2:0]  cfg_wait = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_err;
    logic [31:0] rsp_rdata;
    logic [15:0] ext_addr, ext_dout, ext_din;
    logic        ext_doe, ext_ce_n, ext_oe_n, ext_we_lo_n, ext_we_hi_n, ext_bs_lo_n, ext_bs_hi_n;

    logic [7:0] mem [0:MEM_N-1];
    logic [7:0] ref_mem [0:MEM_N-1];
    int errs = 0;
    int checks = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbc_ctrl u_sbc_ctrl (
        .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_bsel(cfg_bsel), .cfg_wait(cfg_wait),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_doe(ext_doe), .ext_din(ext_din),
        .ext_ce_n(ext_ce_n), .ext_oe_n(ext_oe_n), .ext_we_lo_n(ext_we_lo_n), .ext_we_hi_n(ext_we_hi_n),
        .ext_bs_lo_n(ext_bs_lo_n), .ext_bs_hi_n(ext_bs_hi_n)
    );

    // SRAM device model; the narrow model drives junk on the unused upper lines
    always_comb begin
        if (!cfg_wide)
            ext_din = {8'hA5, mem[ext_addr[9:0]]};
        else
            ext_din = {mem[{ext_addr[8:0], 1'b1}], mem[{ext_addr[8:0], 1'b0}]};
    end

    always @(negedge clk) begin
        if (!ext_ce_n && ext_doe) begin
            if (!cfg_wide) begin
                if (!ext_we_lo_n) mem[ext_addr[9:0]] <= ext_dout[7:0];
            end else if (!cfg_bsel) begin
                if (!ext_we_lo_n) mem[{ext_addr[8:0], 1'b0}] <= ext_dout[7:0];
                if (!ext_we_hi_n) mem[{ext_addr[8:0], 1'b1}] <= ext_dout[15:8];
            end else if (!ext_we_lo_n) begin
                if (!ext_bs_lo_n) mem[{ext_addr[8:0], 1'b0}] <= ext_dout[7:0];
                if (!ext_bs_hi_n) mem[{ext_addr[8:0], 1'b1}] <= ext_dout[15:8];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_read(input logic [1:0] sz, input logic [15:0] a);
        logic [31:0] v = '0;
        for (int k = 0; k < (1 << sz); k++)
            v[8*k +: 8] = ref_mem[(a + k) % MEM_N];
        return v;
    endfunction

    function automatic bit exp_bad(input logic [1:0] sz, input logic [15:0] a);
        return (sz == 2'd3) || (sz == 2'd1 && a[0]) || (sz == 2'd2 && a[1:0] != 2'b00);
    endfunction

    function automatic int exp_beats(input logic [1:0] sz, input logic wide);
        if (wide) return (sz == 2'd2) ? 2 : 1;
        return 1 << sz;
    endfunction

    task automatic do_op(input logic wr, input logic [1:0] sz, input logic [15:0] a,
                         input logic [31:0] wd, input logic wide, input logic bsel, input logic [2:0] w);
        bit e_err;
        int nb, lat, cyc, beats, celow, viol, addr_bad;
        logic [31:0] e_rd, got_rd;
        logic got_err, prev_ce;
        logic [15:0] e_addr;
        string mreq;
        e_err = exp_bad(sz, a);
        nb    = exp_beats(sz, wide);
        lat   = e_err ? 1 : nb * (w + 1) + nb;
        e_rd  = ref_read(sz, a);
        mreq  = !wide ? "R5" : (bsel ? "R7" : "R6");
        cyc = 0; beats = 0; celow = 0; viol = 0; addr_bad = 0; prev_ce = 1'b1;
        cfg_wide = wide; cfg_bsel = bsel; cfg_wait = w;
        req_write = wr; req_size = sz; req_addr = a; req_wdata = wd; req_valid = 1'b1;
        got_err = 1'b0; got_rd = '0;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (!ext_ce_n) begin
                celow++;
                if (prev_ce) begin
                    e_addr = wide ? ((a >> 1) + 16'(beats)) : (a + 16'(beats));
                    if (ext_addr != e_addr) addr_bad++;
                    beats++;
                end
                if (wr && (!ext_oe_n || (ext_we_lo_n && ext_we_hi_n) || !ext_doe)) viol++;
                if (!wr && (ext_oe_n || !ext_we_lo_n || !ext_we_hi_n || ext_doe)) viol++;
            end
            if (!wide && (!ext_we_hi_n || !ext_bs_lo_n || !ext_bs_hi_n)) viol++;
            if (wide && !bsel && (!ext_bs_lo_n || !ext_bs_hi_n)) viol++;
            if (wide && bsel && !ext_we_hi_n) viol++;
            if (wide && bsel && !ext_ce_n && sz != 2'd0 && (ext_bs_lo_n || ext_bs_hi_n)) viol++;
            prev_ce = ext_ce_n;
            if (req_ready) begin
                got_err = rsp_err;
                got_rd  = rsp_rdata;
                break;
            end
            if (cyc > 200) break;
        end
        req_valid = 1'b0;
        chk(cyc == lat, "R9 latency", 32'(cyc), 32'(lat));
        chk(got_err == e_err, e_err ? "R1 error flag" : "R9 error flag", 32'(got_err), 32'(e_err));
        if (e_err) begin
            chk(beats == 0, "R1 no bus cycle", 32'(beats), 0);
        end else begin
            chk(beats == nb, "R2 beat count", 32'(beats), 32'(nb));
            chk(addr_bad == 0, "R2 beat address order", 32'(addr_bad), 0);
            chk(celow == nb * (w + 1), "R8 beat length", 32'(celow), 32'(nb * (w + 1)));
            chk(viol == 0, mreq, 32'(viol), 0);
            if (!wr) begin
                chk(got_rd == e_rd, "R4 read data", got_rd, e_rd);
            end else begin
                bit same = 1;
                for (int k = 0; k < (1 << sz); k++)
                    ref_mem[(a + k) % MEM_N] = wd[8*k +: 8];
                for (int k = -4; k < 8; k++) begin
                    int idx = (int'(a) + k + MEM_N) % MEM_N;
                    if (mem[idx] != ref_mem[idx]) same = 0;
                end
                chk(same, "R3 written bytes", 32'(same), 1);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL R9 watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [1:0] sz;
        logic [15:0] a;
        seed = 17;
        void'($urandom(seed));
        for (int i = 0; i < MEM_N; i++) begin
            mem[i] = 8'(i * 37 + 5);
            ref_mem[i] = 8'(i * 37 + 5);
        end
        repeat (3) @(negedge clk);
        // R10: reset state while reset held
        chk(ext_ce_n && ext_oe_n && ext_we_lo_n && ext_we_hi_n && ext_bs_lo_n && ext_bs_hi_n
            && !ext_doe && !req_ready, "R10 reset outputs",
            {25'd0, ext_ce_n, ext_oe_n, ext_we_lo_n, ext_we_hi_n, ext_bs_lo_n, ext_bs_hi_n, req_ready}, 32'h7E);
        rst = 1'b0;
        @(negedge clk);
        chk(ext_ce_n && !req_ready, "R10 after reset", {30'd0, ext_ce_n, req_ready}, 32'h2);

        // directed corner cases in every port style
        for (int m = 0; m < 3; m++) begin
            logic wd_ = (m != 0);
            logic bs_ = (m == 2);
            do_op(1'b1, 2'd2, 16'h0040 + 16'(m * 8), 32'h44332211, wd_, bs_, 3'd0);
            do_op(1'b0, 2'd2, 16'h0040 + 16'(m * 8), 32'h0, wd_, bs_, 3'd0);
            do_op(1'b1, 2'd0, 16'h0081 + 16'(m * 4), 32'hFFFFFF9C, wd_, bs_, 3'd7);
            do_op(1'b0, 2'd0, 16'h0081 + 16'(m * 4), 32'h0, wd_, bs_, 3'd7);
            do_op(1'b0, 2'd1, 16'h0033, 32'h0, wd_, bs_, 3'd1);   // R1 odd halfword
            do_op(1'b1, 2'd2, 16'h0012, 32'hDEADBEEF, wd_, bs_, 3'd2); // R1 word at 2
            do_op(1'b1, 2'd3, 16'h0010, 32'h12345678, wd_, bs_, 3'd0); // R1 reserved size
            do_op(1'b1, 2'd1, 16'h00A2, 32'h0000CAFE, wd_, bs_, 3'd3);
            do_op(1'b0, 2'd1, 16'h00A2, 32'h0, wd_, bs_, 3'd3);
        end

        // constrained random traffic
        for (int i = 0; i < 400; i++) begin
            logic wide_r, bsel_r;
            sz = 2'($urandom_range(0, 9) == 0 ? 3 : $urandom_range(0, 2));
            a  = 16'($urandom_range(0, 500));
            if ($urandom_range(0, 3) != 0) begin
                if (sz == 2'd1) a[0] = 1'b0;
                if (sz == 2'd2) a[1:0] = 2'b00;
            end
            wide_r = 1'($urandom_range(0, 1));
            bsel_r = 1'($urandom_range(0, 1));
            do_op(1'($urandom_range(0, 1)), sz, a, $urandom(), wide_r, bsel_r, 3'($urandom_range(0, 7)));
        end

        begin
            bit same = 1;
            for (int i = 0; i < MEM_N; i++)
                if (mem[i] != ref_mem[i]) same = 0;
            chk(same, "R3 final memory image", 32'(same), 1);
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule